// File: doc/BRIEF.md
# Two-Speed Square-Wave Divider with Button Control

This block divides a fast system clock down to a square wave at one of two rates. A slow rate is selected after reset; pressing the speed button swaps between slow and fast, and pressing the reset button forces the output low, restarts the count and returns to the slow rate. Each half-period lasts a parameterized number of clock cycles, so the same RTL serves a 50 MHz board (terminal counts 49,999,999 and 4,999,999) and a short simulation.

The four raw button lines are treated as one vector. They are brought into the clock domain through two flip-flop stages, then filtered so that a new vector is accepted only after it has held still for a parameterized number of cycles. Only two exact vectors carry meaning, and each acts on the cycle it is first accepted, so a bouncing or held press acts exactly once.

Top module: `dual_rate_divider`

## Requirements
- R1: While `rst_n` is low and right after it rises, `waveOut` is 0 and `speedFast` is 0 (slow rate).
- R2: In slow mode each level of `waveOut` lasts exactly SLOW_HALF+1 clock cycles.
- R3: In fast mode each level of `waveOut` lasts exactly FAST_HALF+1 clock cycles.
- R4: The accepted button vector 4'b0100 (only bit 2 high) flips `speedFast` exactly once per press, however long the vector is held; releasing it changes nothing.
- R5: The accepted button vector 4'b1000 (only bit 3 high) drives `waveOut` to 0, clears the half-period count and selects slow mode, within DEBOUNCE_CYCLES+4 cycles of the press.
- R6: A button vector is accepted only after it has stayed unchanged for DEBOUNCE_CYCLES consecutive cycles; shorter bursts and bounce have no effect.
- R7: Any other accepted vector (for example 4'b1100, 4'b0010, 4'b0110, 4'b0000) leaves the rate and the waveform unchanged.
- R8: When the speed flips, the half-period count restarts from zero and `waveOut` keeps its level in that cycle, so the first full half-period afterwards already has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| btnRaw | input | 4 | Raw, unsynchronized button lines; bit 3 resets, bit 2 changes speed |
| waveOut | output | 1 | Divided square wave |
| speedFast | output | 1 | 1 when the fast rate is selected |

## Verification
The rate is measured as whole half-periods between output edges, after reset, after single clean presses, after a press that bounces before settling and is then held long, and after a burst shorter than the filter window; these separate a correct single toggle from no toggle or a double toggle. The reset vector is applied just after a rising output edge so a forced low is distinguishable from a natural fall, once from each rate. Mixed and single-bit vectors other than the two commands are applied to show they leave both the rate and the indicator untouched.

// File: rtl/dual_rate_pkg.sv
package dual_rate_pkg;
  localparam int BTN_W = 4;
  localparam logic [BTN_W-1:0] VEC_CLEAR = 4'b1000;
  localparam logic [BTN_W-1:0] VEC_SWAP  = 4'b0100;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // force output low, zero the count
    logic restart;   // zero the count, keep the output level
    logic fast;      // current rate selection
  } rate_cmd_t;
endpackage

// File: rtl/button_conditioner.sv
module button_conditioner #(
  parameter int W   = 4,
  parameter int DEB = 1000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] cleanOut
);
  localparam int DW = (DEB > 1) ? $clog2(DEB) : 1;
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB - 1);

  logic [W-1:0] syncA, syncB;
  logic [W-1:0] cand;
  logic [DW-1:0] holdCnt;

  // Two-stage synchronizer on every line
  for (genvar gi = 0; gi < W; gi++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncA[gi] <= 1'b0;
        syncB[gi] <= 1'b0;
      end else begin
        syncA[gi] <= rawIn[gi];
        syncB[gi] <= syncA[gi];
      end
    end
  end

  // Accept a new vector once it has held for DEB cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleanOut <= '0;
      cand     <= '0;
      holdCnt  <= '0;
    end else if (syncB == cleanOut) begin
      cand    <= cleanOut;
      holdCnt <= '0;
    end else if (syncB != cand) begin
      cand    <= syncB;
      holdCnt <= '0;
    end else if (holdCnt == DEB_LAST) begin
      cleanOut <= cand;
      holdCnt  <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // R6
  accept_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cleanOut) |-> $past(holdCnt) == DEB_LAST);
endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import dual_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BTN_W-1:0] cleanBtn,
  output rate_cmd_t        cmd
);
  logic clearHit, swapHit, clearHitD, swapHitD;
  logic clearPulse, swapPulse, fastMode;

  assign clearHit = (cleanBtn == VEC_CLEAR);
  assign swapHit  = (cleanBtn == VEC_SWAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearHitD <= 1'b0;
      swapHitD  <= 1'b0;
    end else begin
      clearHitD <= clearHit;
      swapHitD  <= swapHit;
    end
  end

  assign clearPulse = clearHit & ~clearHitD;
  assign swapPulse  = swapHit & ~swapHitD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fastMode <= 1'b0;
    else if (clearPulse) fastMode <= 1'b0;
    else if (swapPulse)  fastMode <= ~fastMode;
  end

  assign cmd.clearAll = clearPulse;
  assign cmd.restart  = swapPulse & ~clearPulse;
  assign cmd.fast     = fastMode;

  // R4
  swap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swapPulse |=> !swapPulse);
  // R4
  swap_flips_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swapPulse |=> fastMode != $past(fastMode));
  // R5
  clear_selects_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearPulse |=> !fastMode);
  // R7
  mode_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fastMode) |-> $past(swapPulse || clearPulse));
endmodule

// File: rtl/rate_datapath.sv
module rate_datapath
  import dual_rate_pkg::*;
#(
  parameter int SLOW_HALF = 49999999,
  parameter int FAST_HALF = 4999999
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cmd_t cmd,
  output logic      waveOut
);
  localparam int CW = $clog2(SLOW_HALF + 1);
  localparam logic [CW-1:0] SLOW_T = CW'(SLOW_HALF);
  localparam logic [CW-1:0] FAST_T = CW'(FAST_HALF);

  logic [CW-1:0] halfCnt;
  logic [CW-1:0] term;

  assign term = cmd.fast ? FAST_T : SLOW_T;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfCnt <= '0;
      waveOut <= 1'b0;
    end else if (cmd.clearAll) begin
      halfCnt <= '0;
      waveOut <= 1'b0;
    end else if (cmd.restart) begin
      halfCnt <= '0;
    end else if (halfCnt == term) begin
      halfCnt <= '0;
      waveOut <= ~waveOut;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halfCnt <= SLOW_T);
  // R5
  clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clearAll |=> (!waveOut && halfCnt == '0));
  // R8
  restart_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.restart |=> (halfCnt == '0 && $stable(waveOut)));
  // R3
  edge_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(waveOut) |-> ($past(cmd.clearAll) || $past(halfCnt) == $past(term)));
endmodule

// File: rtl/dual_rate_divider.sv
module dual_rate_divider #(
  parameter int SLOW_HALF       = 49999999,
  parameter int FAST_HALF       = 4999999,
  parameter int DEBOUNCE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] btnRaw,
  output logic       waveOut,
  output logic       speedFast
);
  import dual_rate_pkg::*;

  logic [BTN_W-1:0] cleanBtn;
  rate_cmd_t        cmd;

  button_conditioner #(.W(BTN_W), .DEB(DEBOUNCE_CYCLES)) u_cond (
    .clk(clk), .rst_n(rst_n), .rawIn(btnRaw), .cleanOut(cleanBtn)
  );

  rate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cleanBtn(cleanBtn), .cmd(cmd)
  );

  rate_datapath #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .waveOut(waveOut)
  );

  assign speedFast = cmd.fast;
endmodule

// File: tb/dual_rate_divider_tb.sv
module dual_rate_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 19;
  localparam int FAST = 4;
  localparam int DEB  = 8;

  typedef struct {
    bit    fast;
    int    half;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] btnRaw = 4'b0000;
  logic waveOut, speedFast;
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rate_divider #(.SLOW_HALF(SLOW), .FAST_HALF(FAST), .DEBOUNCE_CYCLES(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .btnRaw(btnRaw), .waveOut(waveOut), .speedFast(speedFast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input logic [3:0] v, input int n);
    btnRaw = v;
    cycles(n);
  endtask

  // Driver: push an expected rate and wait until the monitor consumes it
  task automatic expectRate(input bit fast, input int half, input string tag);
    exp_t e;
    e.fast = fast;
    e.half = half;
    e.tag  = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  // Monitor: measure one whole half-period and compare
  initial begin
    forever begin
      exp_t e;
      logic lvl;
      int n;
      wait (expQ.size() > 0);
      e = expQ[0];
      @(negedge clk);
      lvl = waveOut;
      while (waveOut == lvl) @(negedge clk);
      lvl = waveOut;
      n = 0;
      while (waveOut == lvl) begin
        @(negedge clk);
        n++;
      end
      check(n == e.half, {e.tag, " half-period"}, n, e.half);
      check(speedFast == e.fast, {e.tag, " rate flag"}, speedFast, e.fast);
      void'(expQ.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cycles(3);
    // R1 reset state
    check(waveOut == 1'b0, "R1 wave in reset", waveOut, 0);
    check(speedFast == 1'b0, "R1 rate in reset", speedFast, 0);
    rst_n = 1'b1;
    cycles(1);
    check(waveOut == 1'b0 && speedFast == 1'b0, "R1 after release", {waveOut, speedFast}, 0);

    // R2 slow rate
    expectRate(1'b0, SLOW + 1, "R2");

    // R6 bouncing press then long hold: one toggle only (R4)
    for (int i = 0; i < 3; i++) begin
      hold(4'b0100, 2);
      hold(4'b0000, 2);
    end
    hold(4'b0100, 40);
    check(speedFast == 1'b1, "R4 R6 bounced press", speedFast, 1);
    // R3 R8 fast rate after the swap
    expectRate(1'b1, FAST + 1, "R3 R8");
    hold(4'b0000, 20);
    check(speedFast == 1'b1, "R4 release no effect", speedFast, 1);

    // R6 short burst ignored
    hold(4'b0100, 4);
    hold(4'b0000, 30);
    check(speedFast == 1'b1, "R6 short burst", speedFast, 1);
    expectRate(1'b1, FAST + 1, "R6 rate kept");

    // R4 second press returns to slow
    hold(4'b0100, 20);
    hold(4'b0000, 20);
    check(speedFast == 1'b0, "R4 second press", speedFast, 0);
    expectRate(1'b0, SLOW + 1, "R4 slow again");

    // R5 clear from slow, applied just after a rising edge
    while (waveOut != 1'b0) @(negedge clk);
    while (waveOut != 1'b1) @(negedge clk);
    hold(4'b1000, DEB + 5);
    for (int i = 0; i < 8; i++) begin
      check(waveOut == 1'b0, "R5 forced low", waveOut, 0);
      cycles(1);
    end
    hold(4'b0000, 20);
    expectRate(1'b0, SLOW + 1, "R5 slow after clear");

    // R5 clear from fast
    hold(4'b0100, 20);
    hold(4'b0000, 20);
    check(speedFast == 1'b1, "R4 to fast", speedFast, 1);
    hold(4'b1000, 20);
    hold(4'b0000, 20);
    check(speedFast == 1'b0, "R5 clear selects slow", speedFast, 0);
    expectRate(1'b0, SLOW + 1, "R5 rate after clear");

    // R7 other vectors have no effect
    hold(4'b1100, 20);
    hold(4'b0000, 20);
    check(speedFast == 1'b0, "R7 vector 1100", speedFast, 0);
    hold(4'b0010, 20);
    hold(4'b0110, 20);
    hold(4'b0000, 20);
    check(speedFast == 1'b0, "R7 vectors 0010 0110", speedFast, 0);
    expectRate(1'b0, SLOW + 1, "R7 rate kept");

    summary();
  end
endmodule